// File: doc/BRIEF.md
# Single-Precision Inverse Square Root Operand Screen

This block sits ahead of an iterative reciprocal-square-root datapath for IEEE-754 binary32 values. Each clock it takes one operand and sorts it into a class. Operands the iteration cannot handle are infinity, negative nonzero values and zeros. For these it produces fixed replacement results and clears the proceed flag. Every other operand is handed on with proceed set and a seed of zero.

Operands whose biased exponent field is 24 or less are multiplied exactly by 2^64 so that the later iteration keeps full precision. Subnormals in this range are renormalised with no mantissa bits lost. Such operands are tagged with adjust code 0xE0 so that a later stage can correct the result exponent.

The class is held in a small enumerated state register with six states:
- IDLE: the value after reset.
- INF, NEG, ZERO: the special classes.
- SCALE: a small-exponent operand that was prescaled.
- PASS: an operand handed on unchanged.

Each transition goes from any state to the class of the operand presented in that cycle. The classes are tested in priority order: infinity, then negative nonzero, then zero, then the normal path. The output process decodes the registered state.

Top module: `rsqrt_fixup`

## Requirements
- R1: An infinite operand (exponent field all ones, mantissa zero, either sign) gives op_out = seed_out = 0xFFFFFFFF, invalid_out = 1, proceed_out = 0 and adj_out = 0.
- R2: A negative nonzero, non-NaN operand (sign bit 31 set, including negative subnormals) gives op_out = seed_out = 0xFFFFFFFF, invalid_out = 1, proceed_out = 0 and adj_out = 0.
- R3: A zero of either sign gives op_out equal to the operand, seed_out = 0x3F800000 (1.0), proceed_out = 0, invalid_out = 0 and adj_out = 0.
- R4: A NaN (exponent field all ones, mantissa nonzero, either sign) is passed through unchanged, with proceed_out = 1, invalid_out = 0, adj_out = 0 and seed_out = 0.
- R5: A positive normal operand with exponent field 1 to 24 gives op_out with the same sign and mantissa and an exponent field raised by 64, with adj_out = 0xE0, proceed_out = 1, invalid_out = 0 and seed_out = 0.
- R6: A positive subnormal operand gives op_out equal in value to the operand times 2^64, as a normalised number (exponent field nonzero), with adj_out = 0xE0 and proceed_out = 1.
- R7: A positive operand with exponent field 25 to 254 is passed through unchanged, with adj_out = 0, proceed_out = 1, invalid_out = 0 and seed_out = 0.
- R8: Results appear on the outputs one clock edge after the operand is presented. While reset is held, all outputs are zero.
- R9: proceed_out and invalid_out are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_in | input | 32 | binary32 operand |
| op_out | output | 32 | Screened, possibly prescaled operand |
| seed_out | output | 32 | Seed or replacement result |
| adj_out | output | 8 | Exponent adjust code (0xE0 when prescaled) |
| proceed_out | output | 1 | Operand should enter the iteration |
| invalid_out | output | 1 | Invalid-operation flag |

## Verification
The hardest cases to reach are the subnormal renormalisation and the boundaries of the priority order. The subnormal path must be correct for every leading-one position. At the boundaries, negative zero, negative NaN and negative infinity each have to land in a different class from other negative values. The bench sweeps every exponent field value with both signs against a mantissa set. That set holds zero, dense patterns and a single set bit at each of the 23 positions, so that every leading-one position is exercised. For the prescaled cases, the bench computes the expected value in real arithmetic, independently of the bit-level result.

// File: rtl/rsqf_pkg.sv
package rsqf_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int ADJ_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INF   = 3'd1,
        ST_NEG   = 3'd2,
        ST_ZERO  = 3'd3,
        ST_SCALE = 3'd4,
        ST_PASS  = 3'd5
    } screen_st_e;
endpackage

// File: rtl/rsqf_classify.sv
module rsqf_classify
    import rsqf_pkg::*;
#(
    parameter int SMALL_LIMIT = 24
) (
    input  logic [WORD_W-1:0] operand,
    output screen_st_e        cls
);
    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic             is_inf, is_nan, is_zero;

    always_comb begin
        sgn     = operand[WORD_W-1];
        ex      = operand[WORD_W-2:MAN_W];
        mn      = operand[MAN_W-1:0];
        is_inf  = (ex == EXP_ONES) && (mn == '0);
        is_nan  = (ex == EXP_ONES) && (mn != '0);
        is_zero = (ex == '0) && (mn == '0);
    end

    always_comb begin
        if (is_inf)
            cls = ST_INF;
        else if (sgn && !is_zero && !is_nan)
            cls = ST_NEG;
        else if (is_zero)
            cls = ST_ZERO;
        else if (!is_nan && (int'(ex) <= SMALL_LIMIT))
            cls = ST_SCALE;
        else
            cls = ST_PASS;
    end
endmodule

// File: rtl/rsqf_prescale.sv
module rsqf_prescale
    import rsqf_pkg::*;
#(
    parameter int SCALE_POW = 64
) (
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] scaled
);
    localparam int LEAD_W = $clog2(MAN_W);

    logic [EXP_W-1:0]  ex;
    logic [MAN_W-1:0]  mn;
    logic [LEAD_W-1:0] lead;
    logic [MAN_W-1:0]  norm_mn;
    logic [EXP_W-1:0]  norm_ex;

    assign ex = operand[WORD_W-2:MAN_W];
    assign mn = operand[MAN_W-1:0];

    // leading-one position of a subnormal mantissa
    always_comb begin
        lead = '0;
        for (int i = 0; i < MAN_W; i++) begin
            if (mn[i]) lead = LEAD_W'(i);
        end
    end

    always_comb begin
        norm_mn = mn << (MAN_W - int'(lead));
        norm_ex = EXP_W'(int'(lead) + 1 - MAN_W + SCALE_POW);
        if (ex == '0)
            scaled = {operand[WORD_W-1], norm_ex, norm_mn};
        else
            scaled = {operand[WORD_W-1], EXP_W'(int'(ex) + SCALE_POW), mn};
    end
endmodule

// File: rtl/rsqrt_fixup.sv
module rsqrt_fixup
    import rsqf_pkg::*;
#(
    parameter int              SMALL_LIMIT = 24,
    parameter int              SCALE_POW   = 64,
    parameter logic [ADJ_W-1:0] ADJ_SCALED = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_in,
    output logic [WORD_W-1:0] op_out,
    output logic [WORD_W-1:0] seed_out,
    output logic [ADJ_W-1:0]  adj_out,
    output logic              proceed_out,
    output logic              invalid_out
);
    localparam logic [WORD_W-1:0] QNAN_ALL = '1;
    localparam logic [WORD_W-1:0] ONE_VAL  = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

    screen_st_e        st_d, st_q;
    logic [WORD_W-1:0] scaled_w;
    logic [WORD_W-1:0] opnd_q;

    rsqf_classify #(.SMALL_LIMIT(SMALL_LIMIT)) classify_i (
        .operand (op_in),
        .cls     (st_d)
    );

    rsqf_prescale #(.SCALE_POW(SCALE_POW)) prescale_i (
        .operand (op_in),
        .scaled  (scaled_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            opnd_q <= '0;
        end else begin
            st_q   <= st_d;
            opnd_q <= (st_d == ST_SCALE) ? scaled_w : op_in;
        end
    end

    // output decode
    always_comb begin
        op_out      = '0;
        seed_out    = '0;
        adj_out     = '0;
        proceed_out = 1'b0;
        invalid_out = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_INF, ST_NEG: begin
                op_out      = QNAN_ALL;
                seed_out    = QNAN_ALL;
                invalid_out = 1'b1;
            end
            ST_ZERO: begin
                op_out   = opnd_q;
                seed_out = ONE_VAL;
            end
            ST_SCALE: begin
                op_out      = opnd_q;
                adj_out     = ADJ_SCALED;
                proceed_out = 1'b1;
            end
            ST_PASS: begin
                op_out      = opnd_q;
                proceed_out = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rsqrt_fixup_chk.sv
module rsqrt_fixup_chk
    import rsqf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] op_in,
    input logic [WORD_W-1:0] op_out,
    input logic [WORD_W-1:0] seed_out,
    input logic [ADJ_W-1:0]  adj_out,
    input logic              proceed_out,
    input logic              invalid_out
);
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    logic in_inf, in_nan, in_zero;
    assign in_inf  = (op_in[30:23] == 8'hFF) && (op_in[22:0] == '0);
    assign in_nan  = (op_in[30:23] == 8'hFF) && (op_in[22:0] != '0);
    assign in_zero = (op_in[30:0] == '0);

    assert_inf_to_nan_R1: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(in_inf) |-> (op_out == '1) && (seed_out == '1) && invalid_out);

    assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(in_zero) |-> (seed_out == 32'h3F800000) && (op_out == $past(op_in)));

    assert_nan_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(in_nan) |-> (op_out == $past(op_in)) && proceed_out && !invalid_out);

    assert_scaled_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_out != '0) |-> (op_out[30:23] != '0) && proceed_out);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(proceed_out && invalid_out));

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |-> (op_out == '0) && !proceed_out && !invalid_out);
endmodule

bind rsqrt_fixup rsqrt_fixup_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_in       (op_in),
    .op_out      (op_out),
    .seed_out    (seed_out),
    .adj_out     (adj_out),
    .proceed_out (proceed_out),
    .invalid_out (invalid_out)
);

// File: tb/rsqrt_fixup_tb.sv
module rsqrt_fixup_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_in = '0;
    logic [31:0] op_out, seed_out;
    logic [7:0]  adj_out;
    logic        proceed_out, invalid_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rsqrt_fixup dut_i (
        .clk(clk), .rst_n(rst_n), .op_in(op_in), .op_out(op_out),
        .seed_out(seed_out), .adj_out(adj_out),
        .proceed_out(proceed_out), .invalid_out(invalid_out)
    );

    function automatic real to_real(input logic [31:0] b);
        real mag;
        int  e;
        e   = int'(b[30:23]);
        mag = real'(b[22:0]);
        if (e == 0) mag = mag * (2.0 ** (-149));
        else        mag = (mag + 8388608.0) * (2.0 ** (e - 150));
        return b[31] ? -mag : mag;
    endfunction

    task automatic check(input string req, input logic [31:0] x,
                         input logic [31:0] exp_op, input logic [31:0] exp_seed,
                         input logic [7:0] exp_adj, input logic exp_pr, input logic exp_inv);
        checks++;
        if (op_out !== exp_op || seed_out !== exp_seed || adj_out !== exp_adj ||
            proceed_out !== exp_pr || invalid_out !== exp_inv) begin
            errors++;
            $display("FAIL %s in=%h got op=%h seed=%h adj=%h pr=%b inv=%b exp op=%h seed=%h adj=%h pr=%b inv=%b",
                     req, x, op_out, seed_out, adj_out, proceed_out, invalid_out,
                     exp_op, exp_seed, exp_adj, exp_pr, exp_inv);
        end
    endtask

    task automatic apply(input logic [31:0] x);
        logic [7:0]  e;
        logic [22:0] m;
        logic        s;
        real         want;
        @(negedge clk);
        op_in = x;
        @(negedge clk);
        e = x[30:23]; m = x[22:0]; s = x[31];
        if (e == 8'hFF && m == 0)
            check("R1", x, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1);
        else if (e == 8'hFF)
            check("R4", x, x, 32'h0, 8'h00, 1'b1, 1'b0);
        else if (s && (e != 0 || m != 0))
            check("R2", x, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1);
        else if (e == 0 && m == 0)
            check("R3", x, x, 32'h3F800000, 8'h00, 1'b0, 1'b0);
        else if (e == 0) begin
            want = to_real(x) * (2.0 ** 64);
            checks++;
            if (to_real(op_out) != want || op_out[30:23] == 0 || op_out[31] ||
                adj_out !== 8'hE0 || proceed_out !== 1'b1 || invalid_out !== 1'b0 ||
                seed_out !== 32'h0) begin
                errors++;
                $display("FAIL R6 in=%h got op=%h adj=%h pr=%b exp value %e adj=e0 pr=1",
                         x, op_out, adj_out, proceed_out, want);
            end
        end else if (e <= 24)
            check("R5", x, {1'b0, e + 8'd64, m}, 32'h0, 8'hE0, 1'b1, 1'b0);
        else
            check("R7", x, x, 32'h0, 8'h00, 1'b1, 1'b0);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        op_in = 32'h3F800000;
        repeat (3) @(negedge clk);
        checks++;
        if (op_out !== 0 || seed_out !== 0 || adj_out !== 0 || proceed_out || invalid_out) begin
            errors++;
            $display("FAIL R8 reset outputs op=%h seed=%h adj=%h exp all zero", op_out, seed_out, adj_out);
        end
        rst_n = 1'b1;
        // R8 latency: first result one edge after presentation
        @(negedge clk);
        op_in = 32'h00000000;
        @(negedge clk);
        op_in = 32'hFF800000;
        checks++;
        if (seed_out !== 32'h3F800000) begin
            errors++;
            $display("FAIL R8 latency seed=%h exp 3f800000", seed_out);
        end
        @(negedge clk);
        checks++;
        if (invalid_out !== 1'b1) begin
            errors++;
            $display("FAIL R8 latency invalid=%b exp 1", invalid_out);
        end
        for (int sg = 0; sg < 2; sg++) begin
            for (int ex = 0; ex < 256; ex++) begin
                for (int k = 0; k < 28; k++) begin
                    logic [22:0] mm;
                    if (k < 23)       mm = 23'(1) << k;
                    else if (k == 23) mm = 23'h0;
                    else if (k == 24) mm = 23'h7FFFFF;
                    else if (k == 25) mm = 23'h2AAAAA;
                    else if (k == 26) mm = 23'h555555;
                    else              mm = 23'h400001;
                    apply({sg[0], ex[7:0], mm});
                end
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule